// File: doc/BRIEF.md
# Multi-Mode Address Generation Unit

This unit computes the next value of one address pointer every clock cycle, in parallel with the arithmetic datapath. Each request carries the current pointer, a signed step, a modulus and a two-bit arithmetic select. One cycle later the unit returns the updated pointer and the effective address used for the access. The effective address is the pointer before the update, which is post-update addressing.

Four update arithmetics are available:

- **Plain two's-complement addition.**
- **Circular addition** inside a buffer whose base is aligned to the next power of two at or above the modulus.
- **Multiple-wrap addition.** With a power-of-two modulus, the low bits wrap freely and the high bits stay fixed.
- **Reverse-carry addition.** The carry runs from the most significant bit toward the least, which steps a pointer through bit-reversed order for FFT buffers.

The alignment of a buffer base is derived from the modulus itself, so no separate alignment input is needed.

Top module: `agu_update`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `nxt_ptr` and `eff_addr` become 0 after that edge.
- R2: A request with `in_valid` high at a clock edge produces `out_valid` high after that edge. With `in_valid` low at an edge, `out_valid` is low after it. One request is accepted every cycle.
- R3: When `mode` = 2'b00 (linear), `nxt_ptr` is `ptr + step` modulo 2^32.
- R4: When `mode` = 2'b01 (circular) and `modv` = M > 0, stepping at or beyond `base + M` subtracts M.
- R5: In circular mode, stepping below `base` adds M. This assumes `|step| <= M` and `ptr - base < M`.
- R6: In circular mode, `base` is `ptr` with its low k bits cleared, where 2^k is the smallest power of two that is at or above M. Bits k and up of `nxt_ptr` equal those of `ptr`.
- R7: A modulus of 0 in mode 2'b01 or 2'b10 makes the update behave exactly as linear.
- R8: When `mode` = 2'b10 (multiple-wrap) and `modv` = 2^k, bits k and up of `nxt_ptr` equal those of `ptr`, and the low k bits equal `(ptr + step) mod 2^k`. The step may exceed the modulus.
- R9: When `mode` = 2'b11 (reverse-carry), `nxt_ptr` = rev(rev(`ptr`) + rev(`step`)), where rev mirrors all 32 bits.
- R10: `eff_addr` after an accepted request equals that request's `ptr`.
- R11: With `in_valid` low, `nxt_ptr` and `eff_addr` keep their values across the edge, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 2 | 00 linear, 01 circular, 10 multiple-wrap, 11 reverse-carry |
| ptr | input | 32 | Current pointer |
| step | input | 32 | Signed step (two's complement) |
| modv | input | 32 | Modulus; 0 selects linear behaviour in modes 01 and 10 |
| out_valid | output | 1 | Result registered from a request |
| nxt_ptr | output | 32 | Updated pointer |
| eff_addr | output | 32 | Effective address (pointer before update) |

## Verification
Circular mode is exercised with random moduli, random in-buffer positions and steps up to plus or minus M, so that both wrap directions and the non-wrapping middle all occur. Directed cases with a non-power-of-two modulus separate the alignment rounding (R6) from the simple masking used by multiple-wrap mode. Multiple-wrap mode runs with steps much larger than the modulus, which shows that the carry out of the low field is discarded. Reverse-carry mode is checked with random operands and with the 0, 8, 4, 12 walk of a 16-point buffer. Interleaved idle cycles carry changed inputs, which confirms that the outputs hold.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;

    localparam int ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        AM_LIN   = 2'b00,
        AM_CIRC  = 2'b01,
        AM_MWRAP = 2'b10,
        AM_REVC  = 2'b11
    } agu_mode_e;

    typedef struct packed {
        agu_mode_e mode;
        addr_t     ptr;
        addr_t     step;
        addr_t     modv;
    } agu_req_t;

    // Mirror every bit position of an address word.
    function automatic addr_t mirror(input addr_t v);
        addr_t r;
        for (int i = 0; i < ADDR_W; i++) r[i] = v[ADDR_W-1-i];
        return r;
    endfunction

    // Smear the highest set bit downward: smallest 2^k-1 mask covering v.
    function automatic addr_t smear_down(input addr_t v);
        addr_t r;
        r = v;
        for (int s = 1; s < ADDR_W; s = s * 2) r = r | (r >> s);
        return r;
    endfunction

endpackage

// File: rtl/agu_circ.sv
`timescale 1ns/1ps
module agu_circ
    import agu_pkg::*;
(
    input  addr_t ptr,
    input  addr_t step,
    input  addr_t modv,
    output addr_t nxt
);
    localparam int SW = ADDR_W + 2;

    addr_t                 span_mask;
    addr_t                 base;
    addr_t                 idx;
    logic signed [SW-1:0]  sum;
    logic signed [SW-1:0]  lim;
    logic signed [SW-1:0]  wrapped;

    always_comb begin
        span_mask = smear_down(modv - addr_t'(1));
        base      = ptr & ~span_mask;
        idx       = ptr & span_mask;
        lim       = $signed({2'b00, modv});
        sum       = $signed({2'b00, idx}) + $signed({{2{step[ADDR_W-1]}}, step});
        if (sum >= lim)
            wrapped = sum - lim;
        else if (sum < 0)
            wrapped = sum + lim;
        else
            wrapped = sum;
        nxt = base | (wrapped[ADDR_W-1:0] & span_mask);
    end
endmodule

// File: rtl/agu_mwrap.sv
`timescale 1ns/1ps
module agu_mwrap
    import agu_pkg::*;
(
    input  addr_t ptr,
    input  addr_t step,
    input  addr_t modv,
    output addr_t nxt
);
    addr_t low_mask;
    addr_t raw;

    always_comb begin
        low_mask = modv - addr_t'(1);   // modv = 0 gives all ones: linear
        raw      = ptr + step;
        nxt      = (ptr & ~low_mask) | (raw & low_mask);
    end
endmodule

// File: rtl/agu_revc.sv
`timescale 1ns/1ps
module agu_revc
    import agu_pkg::*;
(
    input  addr_t ptr,
    input  addr_t step,
    output addr_t nxt
);
    addr_t rsum;

    always_comb begin
        rsum = mirror(ptr) + mirror(step);
        nxt  = mirror(rsum);
    end
endmodule

// File: rtl/agu_update.sv
`timescale 1ns/1ps
module agu_update
    import agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  mode,
    input  logic [31:0] ptr,
    input  logic [31:0] step,
    input  logic [31:0] modv,
    output logic        out_valid,
    output logic [31:0] nxt_ptr,
    output logic [31:0] eff_addr
);
    agu_req_t req;
    addr_t    lin_nxt, circ_nxt, mwrap_nxt, revc_nxt, sel_nxt;

    assign req = '{mode: agu_mode_e'(mode), ptr: ptr, step: step, modv: modv};

    assign lin_nxt = req.ptr + req.step;

    agu_circ u_circ (
        .ptr (req.ptr),
        .step(req.step),
        .modv(req.modv),
        .nxt (circ_nxt)
    );

    agu_mwrap u_mwrap (
        .ptr (req.ptr),
        .step(req.step),
        .modv(req.modv),
        .nxt (mwrap_nxt)
    );

    agu_revc u_revc (
        .ptr (req.ptr),
        .step(req.step),
        .nxt (revc_nxt)
    );

    always_comb begin
        unique case (req.mode)
            AM_LIN:   sel_nxt = lin_nxt;
            AM_CIRC:  sel_nxt = (req.modv == '0) ? lin_nxt : circ_nxt;
            AM_MWRAP: sel_nxt = mwrap_nxt;
            AM_REVC:  sel_nxt = revc_nxt;
            default:  sel_nxt = lin_nxt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            nxt_ptr   <= '0;
            eff_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                nxt_ptr  <= sel_nxt;
                eff_addr <= req.ptr;
            end
        end
    end
endmodule

// File: rtl/agu_update_chk.sv
`timescale 1ns/1ps
module agu_update_chk
    import agu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  mode,
    input logic [31:0] ptr,
    input logic [31:0] step,
    input logic [31:0] modv,
    input logic        out_valid,
    input logic [31:0] nxt_ptr,
    input logic [31:0] eff_addr
);
    addr_t circ_keep;
    addr_t wrap_keep;

    assign circ_keep = ~smear_down(modv - addr_t'(1));
    assign wrap_keep = ~(modv - addr_t'(1));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10
    eff_addr_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> eff_addr == $past(ptr));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(nxt_ptr) && $stable(eff_addr));

    // R6
    circ_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b01 && modv != '0)
        |=> (nxt_ptr & $past(circ_keep)) == ($past(ptr) & $past(circ_keep)));

    // R8
    mwrap_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b10 && modv != '0 && $countones(modv) == 1)
        |=> (nxt_ptr & $past(wrap_keep)) == ($past(ptr) & $past(wrap_keep)));

    // R3
    linear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b00) |=> nxt_ptr == $past(ptr + step));
endmodule

bind agu_update agu_update_chk u_chk (.*);

// File: tb/agu_update_tb.sv
`timescale 1ns/1ps
module agu_update_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  mode;
    logic [31:0] ptr, step, modv;
    logic        out_valid;
    logic [31:0] nxt_ptr, eff_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    agu_update u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .ptr(ptr), .step(step), .modv(modv),
        .out_valid(out_valid), .nxt_ptr(nxt_ptr), .eff_addr(eff_addr)
    );

    function automatic logic [31:0] rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] ref_next(input logic [1:0] md, input logic [31:0] p,
                                             input logic [31:0] s, input logic [31:0] m);
        longint base, idx, acc, sz;
        int k;
        if (md == 2'b00 || (md != 2'b11 && m == 0)) return p + s;
        if (md == 2'b11) return rev32(rev32(p) + rev32(s));
        k = 0;
        while ((64'd1 << k) < longint'(m)) k++;
        sz   = 64'd1 << k;
        base = (longint'(p) / sz) * sz;
        idx  = longint'(p) - base;
        acc  = idx + longint'($signed(s));
        if (md == 2'b10) begin
            acc = acc % sz;
            if (acc < 0) acc = acc + sz;
        end else begin
            if (acc >= longint'(m)) acc = acc - longint'(m);
            else if (acc < 0) acc = acc + longint'(m);
        end
        return 32'(base + acc);
    endfunction

    task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", rq, got, exp);
        end
    endtask

    task automatic issue(input string rq, input logic [1:0] md, input logic [31:0] p,
                         input logic [31:0] s, input logic [31:0] m);
        logic [31:0] exp;
        @(negedge clk);
        in_valid = 1'b1; mode = md; ptr = p; step = s; modv = m;
        exp = ref_next(md, p, s, m);
        @(posedge clk); #1;
        check(rq, nxt_ptr, exp);
        check("R10", eff_addr, p);
        check("R2", {31'd0, out_valid}, 32'd1);
    endtask

    task automatic idle_cycle();
        logic [31:0] hold_n, hold_e;
        @(negedge clk);
        hold_n = nxt_ptr; hold_e = eff_addr;
        in_valid = 1'b0; mode = 2'b00;
        ptr = ptr ^ 32'h5A5A_0F0F; step = step + 32'd7;
        @(posedge clk); #1;
        check("R11", nxt_ptr, hold_n);
        check("R11", eff_addr, hold_e);
        check("R2", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1234_ABCD);
        rst = 1'b1; in_valid = 1'b1; mode = 2'b01;
        ptr = 32'hDEAD_BEEF; step = 32'd3; modv = 32'd9;
        repeat (3) @(posedge clk); #1;
        check("R1", nxt_ptr, 32'd0);
        check("R1", eff_addr, 32'd0);
        check("R1", {31'd0, out_valid}, 32'd0);
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;

        // directed corners
        issue("R3", 2'b00, 32'hFFFF_FFFF, 32'd1, 32'd0);
        issue("R3", 2'b00, 32'h0000_0010, 32'hFFFF_FFF0, 32'd0);
        issue("R4", 2'b01, 32'h0000_0109, 32'd1, 32'd10);
        check("R4", nxt_ptr, 32'h0000_0100);
        issue("R5", 2'b01, 32'h0000_0100, 32'hFFFF_FFFF, 32'd10);
        check("R5", nxt_ptr, 32'h0000_0109);
        issue("R6", 2'b01, 32'h1234_5673, 32'd3, 32'd5);
        check("R6", nxt_ptr, 32'h1234_5671);
        issue("R7", 2'b01, 32'h0000_0010, 32'h0000_0030, 32'd0);
        check("R7", nxt_ptr, 32'h0000_0040);
        issue("R7", 2'b10, 32'hFFFF_FFF0, 32'h0000_0020, 32'd0);
        check("R7", nxt_ptr, 32'h0000_0010);
        issue("R8", 2'b10, 32'hABC0_001E, 32'h0000_0025, 32'd16);
        check("R8", nxt_ptr, 32'hABC0_0013);
        idle_cycle();
        issue("R9", 2'b11, 32'd0, 32'd8, 32'd0);
        check("R9", nxt_ptr, 32'd8);
        issue("R9", 2'b11, 32'd8, 32'd8, 32'd0);
        check("R9", nxt_ptr, 32'd4);
        issue("R9", 2'b11, 32'd4, 32'd8, 32'd0);
        check("R9", nxt_ptr, 32'd12);

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [31:0] m, p, s;
            int k;
            case (n % 4)
                0: issue("R3", 2'b00, $urandom, $urandom, $urandom);
                1: begin
                    m = ($urandom % 4096) + 1;
                    k = 0;
                    while ((64'd1 << k) < longint'(m)) k++;
                    p = (($urandom >> k) << k) + ($urandom % m);
                    s = 32'($signed(($urandom % (2 * m + 1))) - $signed(m));
                    issue((n % 8 == 1) ? "R4" : "R5", 2'b01, p, s, m);
                end
                2: begin
                    m = 32'd1 << ($urandom % 13);
                    issue("R8", 2'b10, $urandom, $urandom, m);
                end
                default: issue("R9", 2'b11, $urandom, $urandom, $urandom);
            endcase
            if (n % 37 == 0) idle_cycle();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule